// File: doc/BRIEF.md
# Gated Programmable Down-Counter Channel

This block is one 16-bit binary counting channel of an interval timer. Software programs the channel in two steps. It first writes a control word, which picks the operating mode and the way count bytes are written. It then writes a count of one or two bytes into a holding register. On a later counter-clock pulse the held value is copied into the working counter, and later pulses decrement it. The single output reports terminal count. In the terminal-count mode OUT is low while counting and goes high at zero. In the one-shot mode OUT drops for a programmed number of pulses after each rising edge on the gate.

The counter clock and the gate are asynchronous to the system clock. Each passes through a synchronizer and edge detector. A counter-clock pulse is counted once its falling edge has been seen after a rising edge. All state changes on the system clock.

Top module: `pit_channel`

## Requirements
- R1: After reset OUT is low and the channel holds no count. Count-port writes made before any accepted control word are ignored, so OUT stays low however many pulses follow.
- R2: A control write carries `ctl_mode` (0 = terminal-count interrupt, 1 = gate-triggered one-shot) and `ctl_access`. The access codes are: 2'b01 low byte only, with the high byte taken as zero; 2'b10 high byte only, with the low byte taken as zero; 2'b11 low byte then high byte. A control write with code 2'b00 is ignored entirely, including its mode and its effect on OUT. Every accepted control write restarts the two-byte sequence at the low byte.
- R3: An accepted mode 0 control write drives OUT low on the next system clock. Counting then stays stopped until a count has been loaded.
- R4: A pulse is a synchronized rise followed by a fall of `tclk_in`. The first pulse after a complete count write copies the count into the counter and does not decrement it. In mode 0, OUT goes high at the pulse that takes the counter from 1 to 0. For a count of N this is pulse N+1 after the write.
- R5: In mode 0 a low gate level freezes the counter and a high level lets it decrement. A count written while the gate is low still loads on the next pulse. OUT rises N pulses after the gate goes high, and gate changes never alter OUT.
- R6: In mode 0, completing a count write drives OUT low on the next system clock. The new count loads at the next pulse, and counting continues from the new value, not the old one.
- R7: In mode 0 with access 2'b11, writing the low byte drives OUT low at once and halts decrementing. Writing the high byte then lets the full count load at the next pulse.
- R8: A count of 0 stands for 65536. After terminal count in mode 0 the counter wraps from 0 to FFFF and keeps decrementing. OUT stays high until a control word or a new count is written.
- R9: In mode 1, an accepted control write drives OUT high. A complete count arms the channel. After a gate rising edge, the next pulse loads the count and drives OUT low. OUT returns high at the pulse that takes the counter to zero, N pulses after the load. The gate level has no effect on decrementing in this mode.
- R10: In mode 1, a gate rising edge while OUT is low reloads the counter from the held count at the next pulse, which lengthens the low time.
- R11: In mode 1, a gate rising edge that arrives before any count has armed the channel is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe, one cycle |
| ctl_mode | input | 1 | Mode field of the control word |
| ctl_access | input | 2 | Byte access field of the control word |
| cnt_we | input | 1 | Count byte write strobe, one cycle |
| cnt_data | input | 8 | Count byte |
| tclk_in | input | 1 | Asynchronous counter clock |
| gate_in | input | 1 | Asynchronous gate: level enable in mode 0, trigger in mode 1 |
| timer_out | output | 1 | Channel output |

## Verification
The only visible state is OUT, so a wrong counter value appears late. It shows as OUT rising some pulses too early or too late, which a check placed at the exact pulse count catches. Where the bench cannot reach a condition within a few pulses, the assertions look at it on the next cycle. A lost or extra load shows as an off-by-one in the N+1 count. A gate that wrongly inhibits or enables counting shows as a rise shifted by as many pulses as the gate was held. A broken byte toggle or a missing two-byte suspension shows within a handful of pulses, because the bench builds counts whose wrong reading differs by at least one pulse.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_LOHI = 2'b11
  } acc_e;

  typedef enum logic {
    MD_TC_IRQ  = 1'b0,
    MD_ONESHOT = 1'b1
  } mode_e;

  // one decrement step; wraps 0 -> all ones
  function automatic logic [CNT_W-1:0] ce_next(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  // true when the step taken from v lands on zero
  function automatic logic hits_zero(input logic [CNT_W-1:0] v);
    return v == CNT_W'(1);
  endfunction

  // a single byte in its lane, the other lane cleared
  function automatic logic [CNT_W-1:0] place_byte(input logic [BYTE_W-1:0] b,
                                                 input logic hi);
    return hi ? {b, {BYTE_W{1'b0}}} : {{BYTE_W{1'b0}}, b};
  endfunction

endpackage

// File: rtl/pit_edge_sampler.sv
module pit_edge_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level_o,
  output logic prev_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) begin
        sync_q[i] <= sync_q[i-1];
      end
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign prev_o  = prev_q;

endmodule

// File: rtl/pit_count_load.sv
module pit_count_load
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_accept,
  input  logic [1:0]        ctl_access,
  input  logic              cnt_we,
  input  logic [BYTE_W-1:0] cnt_data,
  output logic [CNT_W-1:0]  cr_o,
  output logic              first_o,
  output logic              done_o
);

  acc_e             acc_q;
  logic             hi_next_q;
  logic [CNT_W-1:0] cr_q;
  logic             wr_ok;

  // a control write in the same cycle wins over a count byte
  assign wr_ok   = cnt_we && !ctl_accept;
  assign first_o = wr_ok && (acc_q == ACC_LOHI) && !hi_next_q;
  assign done_o  = wr_ok && ((acc_q == ACC_LO) || (acc_q == ACC_HI) ||
                             ((acc_q == ACC_LOHI) && hi_next_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= ACC_NONE;
      hi_next_q <= 1'b0;
      cr_q      <= '0;
    end else if (ctl_accept) begin
      acc_q     <= acc_e'(ctl_access);
      hi_next_q <= 1'b0;
    end else if (wr_ok) begin
      unique case (acc_q)
        ACC_LO:   cr_q <= place_byte(cnt_data, 1'b0);
        ACC_HI:   cr_q <= place_byte(cnt_data, 1'b1);
        ACC_LOHI: begin
          if (!hi_next_q) cr_q <= place_byte(cnt_data, 1'b0);
          else            cr_q[CNT_W-1:BYTE_W] <= cnt_data;
          hi_next_q <= !hi_next_q;
        end
        default:  ;
      endcase
    end
  end

  assign cr_o = cr_q;

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              ctl_mode,
  input  logic [1:0]        ctl_access,
  input  logic              cnt_we,
  input  logic [BYTE_W-1:0] cnt_data,
  input  logic              tclk_in,
  input  logic              gate_in,
  output logic              timer_out
);

  // synchronized inputs
  logic tclk_lvl, tclk_prev, gate_lvl, gate_prev;

  pit_edge_sampler #(.STAGES(SYNC_STAGES)) u_tclk_smp (
    .clk(clk), .rst_n(rst_n), .async_in(tclk_in),
    .level_o(tclk_lvl), .prev_o(tclk_prev)
  );

  pit_edge_sampler #(.STAGES(SYNC_STAGES)) u_gate_smp (
    .clk(clk), .rst_n(rst_n), .async_in(gate_in),
    .level_o(gate_lvl), .prev_o(gate_prev)
  );

  // count register and byte sequencing
  logic             ctl_accept, cnt_first, cnt_done;
  logic [CNT_W-1:0] cr_q;

  assign ctl_accept = ctl_we && (ctl_access != ACC_NONE);

  pit_count_load u_cr (
    .clk(clk), .rst_n(rst_n), .ctl_accept(ctl_accept), .ctl_access(ctl_access),
    .cnt_we(cnt_we), .cnt_data(cnt_data),
    .cr_o(cr_q), .first_o(cnt_first), .done_o(cnt_done)
  );

  // channel state
  mode_e            mode_q;
  logic [CNT_W-1:0] ce_q;
  logic             out_q;
  logic             counting_q;
  logic             load_pend_q;
  logic             armed_q;
  logic             trig_pend_q;

  // named events; the sampler resets low, so every fall follows a rise
  logic wr_busy, tclk_pulse, gate_rise, trig_evt, load_evt, dec_evt;

  assign wr_busy    = ctl_accept || cnt_first || cnt_done;
  assign tclk_pulse = tclk_prev && !tclk_lvl;
  assign gate_rise  = gate_lvl && !gate_prev;
  assign trig_evt   = (mode_q == MD_ONESHOT) && armed_q && gate_rise && !wr_busy;
  assign load_evt   = tclk_pulse && !wr_busy &&
                      ((mode_q == MD_ONESHOT) ? trig_pend_q : load_pend_q);
  assign dec_evt    = tclk_pulse && !wr_busy && !load_evt && counting_q &&
                      ((mode_q == MD_ONESHOT) || gate_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= MD_TC_IRQ;
      ce_q        <= '0;
      out_q       <= 1'b0;
      counting_q  <= 1'b0;
      load_pend_q <= 1'b0;
      armed_q     <= 1'b0;
      trig_pend_q <= 1'b0;
    end else if (ctl_accept) begin
      mode_q      <= mode_e'(ctl_mode);
      out_q       <= ctl_mode;
      counting_q  <= 1'b0;
      load_pend_q <= 1'b0;
      armed_q     <= 1'b0;
      trig_pend_q <= 1'b0;
    end else if (cnt_first) begin
      if (mode_q == MD_TC_IRQ) begin
        out_q       <= 1'b0;
        counting_q  <= 1'b0;
        load_pend_q <= 1'b0;
      end
    end else if (cnt_done) begin
      if (mode_q == MD_TC_IRQ) begin
        out_q       <= 1'b0;
        load_pend_q <= 1'b1;
      end else begin
        armed_q     <= 1'b1;
      end
    end else begin
      if (load_evt) begin
        ce_q        <= cr_q;
        counting_q  <= 1'b1;
        load_pend_q <= 1'b0;
        trig_pend_q <= 1'b0;
        if (mode_q == MD_ONESHOT) out_q <= 1'b0;
      end else if (dec_evt) begin
        ce_q <= ce_next(ce_q);
        if (hits_zero(ce_q)) out_q <= 1'b1;
      end
      if (trig_evt) trig_pend_q <= 1'b1;
    end
  end

  assign timer_out = out_q;

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_accept,
  input logic             ctl_mode,
  input logic             cnt_first,
  input logic             cnt_done,
  input logic             load_evt,
  input logic             dec_evt,
  input logic             gate_lvl,
  input logic             oneshot,
  input logic             out_q,
  input logic [CNT_W-1:0] ce_q,
  input logic [CNT_W-1:0] cr_q
);

  p_ctl_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_accept && !ctl_mode) |=> !out_q);

  p_load_copies_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (ce_q == $past(cr_q)));

  p_dec_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_evt |=> (ce_q == $past(ce_q) - CNT_W'(1)));

  p_tc_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_evt && !oneshot && ce_q == CNT_W'(1)) |=> out_q);

  p_gate_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!oneshot && !gate_lvl && !load_evt) |=> $stable(ce_q));

  p_first_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_first && !oneshot) |=> !out_q);

  p_out_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!oneshot && out_q && !ctl_accept && !cnt_first && !cnt_done) |=> out_q);

  p_ctl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_accept && ctl_mode) |=> out_q);

  p_shot_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && oneshot) |=> !out_q);

endmodule

bind pit_channel pit_channel_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_accept(ctl_accept), .ctl_mode(ctl_mode),
  .cnt_first(cnt_first), .cnt_done(cnt_done), .load_evt(load_evt),
  .dec_evt(dec_evt), .gate_lvl(gate_lvl), .oneshot(mode_q == pit_pkg::MD_ONESHOT),
  .out_q(out_q), .ce_q(ce_q), .cr_q(cr_q)
);

// File: tb/pit_channel_tb.sv
module pit_channel_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic       ctl_mode = 1'b0;
  logic [1:0] ctl_access = 2'b00;
  logic       cnt_we = 1'b0;
  logic [7:0] cnt_data = 8'h00;
  logic       tclk_in = 1'b0;
  logic       gate_in = 1'b0;
  logic       timer_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pit_channel dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_mode(ctl_mode),
    .ctl_access(ctl_access), .cnt_we(cnt_we), .cnt_data(cnt_data),
    .tclk_in(tclk_in), .gate_in(gate_in), .timer_out(timer_out)
  );

  // pulses from load until OUT rises in mode 0: the load pulse plus N steps
  function automatic int tc_after(input int n);
    return 1 + ((n == 0) ? 65536 : n);
  endfunction

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (timer_out !== exp) begin
      errors++;
      $display("FAIL %s: timer_out=%0b expected %0b", tag, timer_out, exp);
    end
  endtask

  task automatic ctl(input logic m, input logic [1:0] acc);
    @(negedge clk); ctl_we = 1'b1; ctl_mode = m; ctl_access = acc;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); cnt_we = 1'b1; cnt_data = b;
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      tclk_in = 1'b1; repeat (3) @(negedge clk);
      tclk_in = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic gate_set(input logic v);
    gate_in = v; repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(1'b0, "R1 reset OUT");
    wr(8'h02);
    pulses(5);
    chk(1'b0, "R1 count before control ignored");
  endtask

  task automatic t_mode0_basic;
    gate_set(1'b1);
    ctl(1'b0, 2'b01);
    chk(1'b0, "R3 control drives low");
    wr(8'd4);
    pulses(tc_after(4) - 1);
    chk(1'b0, "R4 low before N+1");
    pulses(1);
    chk(1'b1, "R4 high at N+1");
    pulses(3);
    chk(1'b1, "R8 stays high after wrap");
    ctl(1'b0, 2'b01);
    chk(1'b0, "R3 new control word drives low");
    pulses(5);
    chk(1'b0, "R3 no counting without count");
  endtask

  task automatic t_access_none;
    ctl(1'b0, 2'b01);
    wr(8'd1);
    pulses(2);
    chk(1'b1, "R4 count 1 high after 2 pulses");
    ctl(1'b1, 2'b00);
    chk(1'b1, "R2 access 00 control ignored");
    wr(8'd2);
    chk(1'b0, "R6 count write drives low");
    pulses(2);
    chk(1'b0, "R2 old access kept, still low");
    pulses(1);
    chk(1'b1, "R2 old access kept, high");
  endtask

  task automatic t_gate;
    gate_set(1'b0);
    ctl(1'b0, 2'b01);
    wr(8'd3);
    pulses(6);
    chk(1'b0, "R5 gate low holds");
    gate_set(1'b1);
    pulses(2);
    chk(1'b0, "R5 two pulses after gate");
    pulses(1);
    chk(1'b1, "R5 N pulses after gate");
    gate_set(1'b0);
    chk(1'b1, "R5 gate has no effect on OUT");
  endtask

  task automatic t_rewrite;
    gate_set(1'b1);
    ctl(1'b0, 2'b01);
    wr(8'd5);
    pulses(3);
    wr(8'd4);
    pulses(4);
    chk(1'b0, "R6 continues from new count");
    pulses(1);
    chk(1'b1, "R6 new count reaches zero");
  endtask

  task automatic t_two_byte;
    gate_set(1'b1);
    ctl(1'b0, 2'b11);
    wr(8'd2); wr(8'd0);
    pulses(2);
    chk(1'b0, "R7 two-byte count low");
    pulses(1);
    chk(1'b1, "R7 two-byte count high");
    wr(8'd9);
    chk(1'b0, "R7 first byte forces low");
    wr(8'd0);
    pulses(9);
    wr(8'd5);
    pulses(3);
    chk(1'b0, "R7 first byte suspends counting");
    wr(8'd0);
    pulses(5);
    chk(1'b0, "R7 second byte then load");
    pulses(1);
    chk(1'b1, "R7 reaches zero after reload");
  endtask

  task automatic t_toggle;
    gate_set(1'b1);
    ctl(1'b0, 2'b11);
    wr(8'd7);
    ctl(1'b0, 2'b11);
    wr(8'd2); wr(8'd0);
    pulses(2);
    chk(1'b0, "R2 toggle restart low");
    pulses(1);
    chk(1'b1, "R2 toggle restart at low byte");
  endtask

  task automatic t_msb_only;
    gate_set(1'b1);
    ctl(1'b0, 2'b10);
    wr(8'd1);
    pulses(tc_after(256) - 1);
    chk(1'b0, "R2 high byte only still low");
    pulses(1);
    chk(1'b1, "R2 high byte only gives 256");
  endtask

  task automatic t_zero;
    gate_set(1'b1);
    ctl(1'b0, 2'b01);
    wr(8'd0);
    pulses(300);
    chk(1'b0, "R8 zero count is 65536");
  endtask

  task automatic t_oneshot;
    gate_set(1'b0);
    ctl(1'b1, 2'b01);
    chk(1'b1, "R9 control drives high");
    gate_set(1'b1);
    gate_set(1'b0);
    wr(8'd3);
    pulses(2);
    chk(1'b1, "R11 unarmed trigger ignored");
    gate_set(1'b1);
    chk(1'b1, "R9 waits for pulse");
    pulses(1);
    chk(1'b0, "R9 load pulse drives low");
    gate_set(1'b0);
    pulses(2);
    chk(1'b0, "R9 low during count, gate low");
    pulses(1);
    chk(1'b1, "R9 high at zero");
    pulses(3);
    chk(1'b1, "R9 stays high");
  endtask

  task automatic t_retrigger;
    gate_set(1'b0);
    ctl(1'b1, 2'b01);
    wr(8'd4);
    gate_set(1'b1);
    pulses(3);
    chk(1'b0, "R10 low before retrigger");
    gate_set(1'b0);
    gate_set(1'b1);
    pulses(4);
    chk(1'b0, "R10 retrigger extends low");
    pulses(1);
    chk(1'b1, "R10 high after reload count");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: timer_out=%0b expected finish", timer_out);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0_basic();
    t_access_none();
    t_gate();
    t_rewrite();
    t_two_byte();
    t_toggle();
    t_msb_only();
    t_zero();
    t_oneshot();
    t_retrigger();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule